// File: doc/BRIEF.md
# Dual-Channel Serial Converter Register Front End

This block is the digital side of a two-channel 8-bit voltage converter. A host writes to it over a three-wire serial link: an active-low select, a serial clock and a data line. While select is low, each rising serial clock edge moves one bit into a 16-bit command word, most significant bit first. When select returns high, the word is executed. It can load one or both 8-bit channel registers with its data byte, and it sets or clears the shutdown flag of each channel.

Each channel presents three outputs: its stored code, its shutdown flag and an effective code. The effective code is zero while the channel is shut down and equals the stored code otherwise, and it is meant to drive the converter ladder. The control bits are not decoded as a command field. Each one gates its own function for its own channel.

The block runs on a fast system clock that is at least four times the serial clock rate. All three serial pins pass through two-stage synchronizers, and edges are detected from the synchronized samples.

Top module: `sdac_front`

## Requirements
- R1: While select is low, every rising serial clock edge shifts the data pin into the command word, MSB first. Serial clock edges while select is high shift nothing and cause no change.
- R2: Command word bits, with bit 15 sent first: bits 15..13 spare, bit 12 shutdown B, bit 11 shutdown A, bit 10 spare, bit 9 load B, bit 8 load A, bits 7..0 data with bit 0 sent last.
- R3: On a select rising edge that executes, load A = 1 copies the data byte into the channel A register and load B = 1 copies it into the channel B register. With both bits set, both channels get the same value.
- R4: Every executed command writes both shutdown flags from bits 12 and 11, where 1 means shut down and 0 means active. A load bit of 0 leaves its register unchanged.
- R5: A channel that is shut down drives an effective code of zero and keeps its stored code. Clearing the flag restores the stored code on the effective output.
- R6: The spare bits have no effect on any output.
- R7: A select rising edge that follows fewer than 16 serial clock edges changes nothing. With more than 16 edges, the last 16 bits received are used.
- R8: A command sent as two 8-bit segments, with select held low between them, executes the same as one 16-bit burst.
- R9: Reset clears both registers and both shutdown flags, so both effective codes are zero.
- R10: An active channel's effective code equals its stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data |
| code_a | output | 8 | Stored code, channel A |
| code_b | output | 8 | Stored code, channel B |
| off_a | output | 1 | Shutdown flag, channel A |
| off_b | output | 1 | Shutdown flag, channel B |
| drive_a | output | 8 | Effective code, channel A |
| drive_b | output | 8 | Effective code, channel B |

## Verification
The assertions assume that each serial pin holds its level for at least two system clocks, so that every edge survives the synchronizers. They also assume that data is stable around each rising serial clock edge and that select idles high out of reset. The bench drives the pins with a serial clock period of eight system clocks. It changes data and select only while the serial clock is low, with four clocks of margin on each side. It samples the outputs ten clocks after select rises, which is well past the three-register path from the pins to the channel registers.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int CODE_W   = 8;
  localparam int WORD_W   = 2 * CODE_W;
  localparam int LOAD_POS = CODE_W;       // load A, load B at +1
  localparam int OFF_POS  = CODE_W + 3;   // shutdown A, shutdown B at +1
  localparam int CNT_W    = $clog2(WORD_W + 1);

  // Effective code seen by the converter ladder.
  function automatic logic [CODE_W-1:0] eff_code(input logic [CODE_W-1:0] code,
                                                 input logic off);
    eff_code = off ? '0 : code;
  endfunction

  // Mask of the spare bits in a command word.
  function automatic logic [WORD_W-1:0] spare_mask();
    spare_mask = '0;
    spare_mask[WORD_W-1:OFF_POS+2] = '1;
    spare_mask[OFF_POS-1]          = 1'b1;
  endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= pin_i[i];
        s2 <= s1;
      end
    end
    assign sync_o[i] = s2;
  end
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
  import sdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              sclk_s,
  input  logic              din_s,
  output logic [WORD_W-1:0] word_o,
  output logic              fire_o
);
  logic             sel_q, sclk_q;
  logic [CNT_W-1:0] bit_cnt;
  logic             clk_rise, sel_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      sel_q  <= sel_s;
      sclk_q <= sclk_s;
    end
  end

  assign clk_rise = sclk_s & ~sclk_q & ~sel_s;
  assign sel_rise = sel_s & ~sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o  <= '0;
      bit_cnt <= '0;
    end else begin
      if (clk_rise) word_o <= {word_o[WORD_W-2:0], din_s};
      if (sel_s) bit_cnt <= '0;
      else if (clk_rise && bit_cnt != CNT_W'(WORD_W)) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign fire_o = sel_rise && (bit_cnt == CNT_W'(WORD_W));

  AST_SHIFT_SEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_o) |-> !$past(sel_s)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W)); // R7
  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o); // R7
endmodule

// File: rtl/sdac_chan.sv
module sdac_chan
  import sdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              load_i,
  input  logic              off_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o,
  output logic              off_o,
  output logic [CODE_W-1:0] drive_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= '0;
      off_o  <= 1'b0;
    end else if (fire_i) begin
      if (load_i) code_o <= data_i;
      off_o <= off_i;
    end
  end

  assign drive_o = eff_code(code_o, off_o);

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fire_i && load_i) |-> code_o == $past(data_i)); // R3
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fire_i && load_i) |-> $stable(code_o)); // R7
  AST_OFF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fire_i) |-> off_o == $past(off_i)); // R4
  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    off_o |-> drive_o == '0); // R5
  AST_ACTIVE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !off_o |-> drive_o == code_o); // R10
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              off_a,
  output logic              off_b,
  output logic [CODE_W-1:0] drive_a,
  output logic [CODE_W-1:0] drive_b
);
  localparam int NCH = 2;

  logic [2:0]        pins_s;
  logic [WORD_W-1:0] cmd_word;
  logic              cmd_fire;
  logic [WORD_W-1:0] spare_bits;
  logic [CODE_W-1:0] code_w  [NCH];
  logic [CODE_W-1:0] drive_w [NCH];
  logic [NCH-1:0]    off_w;

  sdac_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_i({sel_n, sclk, sdin}), .sync_o(pins_s));

  sdac_shift i_shift (
    .clk(clk), .rst_n(rst_n),
    .sel_s(pins_s[2]), .sclk_s(pins_s[1]), .din_s(pins_s[0]),
    .word_o(cmd_word), .fire_o(cmd_fire));

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    sdac_chan i_chan (
      .clk(clk), .rst_n(rst_n), .fire_i(cmd_fire),
      .load_i(cmd_word[LOAD_POS+g]), .off_i(cmd_word[OFF_POS+g]),
      .data_i(cmd_word[CODE_W-1:0]),
      .code_o(code_w[g]), .off_o(off_w[g]), .drive_o(drive_w[g]));
  end

  assign spare_bits = cmd_word & spare_mask();

  assign code_a  = code_w[0];
  assign code_b  = code_w[1];
  assign off_a   = off_w[0];
  assign off_b   = off_w[1];
  assign drive_a = drive_w[0];
  assign drive_b = drive_w[1];

  AST_BOTH_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_word[LOAD_POS] && cmd_word[LOAD_POS+1]) |=> code_a == code_b); // R3
  AST_SPARE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && spare_bits != '0) |=> (off_a == $past(cmd_word[OFF_POS])) &&
                                       (off_b == $past(cmd_word[OFF_POS+1]))); // R6
endmodule

// File: tb/test_sdac_front.sv
module test_sdac_front;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [15:0] word;
    logic [7:0]  ea;
    logic [7:0]  eb;
    logic        oa;
    logic        ob;
  } vec_t;

  // Sequential vectors: the expected state accumulates from one entry to the next.
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'h0380, 8'h80, 8'h80, 1'b0, 1'b0},  // R3 load both with 0x80
    '{16'h0155, 8'h55, 8'h80, 1'b0, 1'b0},  // R3 load A only
    '{16'h02AA, 8'h55, 8'hAA, 1'b0, 1'b0},  // R3 load B only
    '{16'h1800, 8'h55, 8'hAA, 1'b1, 1'b1},  // R5 both shut down, codes kept
    '{16'h0000, 8'h55, 8'hAA, 1'b0, 1'b0},  // R4 restore
    '{16'h0833, 8'h55, 8'hAA, 1'b1, 1'b0},  // R4 shutdown A, no load
    '{16'hE4FF, 8'h55, 8'hAA, 1'b0, 1'b0},  // R6 spare bits only
    '{16'h1301, 8'h01, 8'h01, 1'b0, 1'b1}   // R2 combined load and shutdown
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic sclk = 1'b0;
  logic sdin = 1'b0;
  logic [7:0] code_a, code_b, drive_a, drive_b;
  logic off_a, off_b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  sdac_front i_sdac_front (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
    .code_a(code_a), .code_b(code_b), .off_a(off_a), .off_b(off_b),
    .drive_a(drive_a), .drive_b(drive_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic chk_state(input string rq, input logic [7:0] ea, input logic [7:0] eb,
                           input logic oa, input logic ob);
    chk({rq, " code_a"}, code_a, ea);
    chk({rq, " code_b"}, code_b, eb);
    chk({rq, " off_a"}, {7'd0, off_a}, {7'd0, oa});
    chk({rq, " off_b"}, {7'd0, off_b}, {7'd0, ob});
    chk({rq, "/R5/R10 drive_a"}, drive_a, oa ? 8'h00 : ea);
    chk({rq, "/R5/R10 drive_b"}, drive_b, ob ? 8'h00 : eb);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdin = w[i];
      wait_clk(HALF_SCK);
      sclk = 1'b1;
      wait_clk(HALF_SCK);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] w, input int n);
    sel_n = 1'b0;
    wait_clk(4);
    send_bits(w, n);
    wait_clk(4);
    sel_n = 1'b1;
    wait_clk(10);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    chk_state("R9 reset", 8'h00, 8'h00, 1'b0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      frame({16'h0, VECS[v].word}, 16);
      chk_state($sformatf("R3/R4 vec%0d", v), VECS[v].ea, VECS[v].eb, VECS[v].oa, VECS[v].ob);
    end

    // R7: short frame of 8 bits does nothing
    frame(32'h0000_00FF, 8);
    chk_state("R7 short", 8'h01, 8'h01, 1'b0, 1'b1);

    // R7: 20 bits, the last 16 count (leading 0x3 nibble dropped)
    frame(32'h0003_0177, 20);
    chk_state("R7 long", 8'h77, 8'h01, 1'b0, 1'b0);

    // R8: two 8-bit segments with select held low
    sel_n = 1'b0;
    wait_clk(4);
    send_bits(32'h0000_0002, 8);
    wait_clk(40);
    send_bits(32'h0000_00C4, 8);
    wait_clk(4);
    sel_n = 1'b1;
    wait_clk(10);
    chk_state("R8 segmented", 8'h77, 8'hC4, 1'b0, 1'b0);

    // R1: a full word clocked with select high, then an empty select pulse
    send_bits(32'h0000_1BEE, 16);
    wait_clk(4);
    sel_n = 1'b0;
    wait_clk(6);
    sel_n = 1'b1;
    wait_clk(10);
    chk_state("R1 select high", 8'h77, 8'hC4, 1'b0, 1'b0);

    // R5: shut B, then restore and see the kept code again
    frame(32'h0000_1000, 16);
    chk_state("R5 shut B", 8'h77, 8'hC4, 1'b0, 1'b1);
    frame(32'h0000_0000, 16);
    chk_state("R5 restore B", 8'h77, 8'hC4, 1'b0, 1'b0);

    // R9: reset in mid-run
    rst_n = 1'b0;
    wait_clk(2);
    chk_state("R9 mid reset", 8'h00, 8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;
    wait_clk(3);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule